// File: doc/BRIEF.md
# Interrupt Enable Deferral Controller

This block owns the processor's interrupt-enable flag and decides, at each between-instruction test point, whether a pending interrupt is taken. The microsequencer reports each micro-order it executes on a small code bus. An interrupt-off order drops the enable flag. Instructions such as indirect jumps, indirect subroutine calls and most I/O operations issue this order so that the next instruction runs before any interrupt is taken. The dispatch jump that starts the next instruction raises the flag again.

A long chain of indirect address steps could otherwise hold interrupts off forever. When the memory-protection option is fitted, a run of consecutive indirect-increment orders therefore also raises the flag. The run length is three by default. Because the flag is already set when the following instruction is dispatched, that instruction sees pending interrupts if it polls for them itself. The deferral only covers the window up to that dispatch.

The accept output is combinational. It is high when the flag is set, a request is pending and the test point is active.

Top module: `iedc_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the enable flag and the indirect-run counter are both cleared. After reset, the first indirect step counts as step one of a run.
- R2: A valid micro-order with code 1 (interrupt-off) clears `inten` at the next clock edge.
- R3: A valid micro-order with code 2 (dispatch) sets `inten` at the next clock edge.
- R4: With `prot_present` high, the IND_LIMIT-th consecutive valid micro-order with code 3 (indirect step) sets `inten` at that clock edge (the third step by default). Further consecutive steps keep the counter saturated and do not clear the flag.
- R5: Any valid micro-order whose code is not 3 restarts the indirect run. Codes 0 (other), 1 and 2 all do this, so two steps, an other order and two more steps leave `inten` unchanged.
- R6: A cycle with `uo_valid` low changes neither `inten` nor the indirect-run count.
- R7: With `prot_present` low, no number of indirect steps sets `inten`. Only the dispatch order can raise it.
- R8: `int_accept` is high in the same cycle if and only if `inten`, `irq_pending` and `test_point` are all high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uo_valid | input | 1 | A micro-order executes this cycle |
| uo_kind | input | 2 | Micro-order code: 0 other, 1 interrupt-off, 2 dispatch, 3 indirect step |
| prot_present | input | 1 | Memory-protection option fitted (strap) |
| irq_pending | input | 1 | An interrupt request is pending |
| test_point | input | 1 | Between-instruction interrupt test is being made |
| inten | output | 1 | Interrupt-enable flag |
| int_accept | output | 1 | Pending interrupt is taken this cycle |

## Verification
The bench applies every sequence of four cycles drawn from idle plus the four micro-order codes, with the strap both high and low. Each step is checked against an arithmetic model of the flag and the run counter. These sequences separate a run of indirect steps that reaches the limit from one that is broken by another order or only paused by an idle cycle. They also show whether interrupt-off and dispatch act on their own, and whether the strap gates the chain release. Reset is inserted at irregular points so that a counter left over from the previous sequence would show up. During every step the request and test-point inputs cycle through their combinations, which exposes an accept output that ignores any one of its three terms.

// File: rtl/iedc_pkg.sv
package iedc_pkg;

    typedef enum logic [1:0] {
        UO_OTHER    = 2'd0,
        UO_INTOFF   = 2'd1,
        UO_DISPATCH = 2'd2,
        UO_INDSTEP  = 2'd3
    } uorder_e;

    typedef struct packed {
        logic intoff;
        logic dispatch;
        logic indstep;
        logic breaks_run;
    } uo_pulse_t;

    function automatic uo_pulse_t decode_order(input logic valid, input uorder_e kind);
        uo_pulse_t p;
        p.intoff     = valid && (kind == UO_INTOFF);
        p.dispatch   = valid && (kind == UO_DISPATCH);
        p.indstep    = valid && (kind == UO_INDSTEP);
        p.breaks_run = valid && (kind != UO_INDSTEP);
        return p;
    endfunction

endpackage

// File: rtl/iedc_order_decode.sv
module iedc_order_decode
    import iedc_pkg::*;
(
    input  logic       uo_valid,
    input  logic [1:0] uo_kind,
    output uo_pulse_t  pulses
);
    always_comb begin
        pulses = decode_order(uo_valid, uorder_e'(uo_kind));
    end
endmodule

// File: rtl/iedc_chain_count.sv
module iedc_chain_count #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic restart,
    input  logic strap,
    output logic release_en
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CMAX  = CW'(LIMIT);
    localparam logic [CW-1:0] CLAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (step) begin
            if (cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
        end else if (restart) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // the step that brings the run to the limit (or any later one) releases
    assign release_en = step && strap && (cnt_q >= CLAST);
endmodule

// File: rtl/iedc_enable_reg.sv
module iedc_enable_reg (
    input  logic clk,
    input  logic rst,
    input  logic clear_en,
    input  logic set_dispatch,
    input  logic set_chain,
    output logic en_q
);
    always_ff @(posedge clk) begin
        if (rst)                           en_q <= 1'b0;
        else if (clear_en)                 en_q <= 1'b0;
        else if (set_dispatch || set_chain) en_q <= 1'b1;
    end
endmodule

// File: rtl/iedc_ctrl.sv
module iedc_ctrl
    import iedc_pkg::*;
#(
    parameter int IND_LIMIT = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       uo_valid,
    input  logic [1:0] uo_kind,
    input  logic       prot_present,
    input  logic       irq_pending,
    input  logic       test_point,
    output logic       inten,
    output logic       int_accept
);
    uo_pulse_t pulses;
    logic      chain_rel;

    iedc_order_decode u_dec (
        .uo_valid (uo_valid),
        .uo_kind  (uo_kind),
        .pulses   (pulses)
    );

    iedc_chain_count #(.LIMIT(IND_LIMIT)) u_chain (
        .clk        (clk),
        .rst        (rst),
        .step       (pulses.indstep),
        .restart    (pulses.breaks_run),
        .strap      (prot_present),
        .release_en (chain_rel)
    );

    iedc_enable_reg u_en (
        .clk          (clk),
        .rst          (rst),
        .clear_en     (pulses.intoff),
        .set_dispatch (pulses.dispatch),
        .set_chain    (chain_rel),
        .en_q         (inten)
    );

    assign int_accept = inten && irq_pending && test_point;
endmodule

// File: rtl/iedc_ctrl_chk.sv
module iedc_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       uo_valid,
    input logic [1:0] uo_kind,
    input logic       prot_present,
    input logic       irq_pending,
    input logic       test_point,
    input logic       inten,
    input logic       int_accept
);
    // R2
    intoff_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (uo_valid && uo_kind == 2'd1) |=> !inten);

    // R3
    dispatch_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (uo_valid && uo_kind == 2'd2) |=> inten);

    // R6
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !uo_valid |=> $stable(inten));

    // R4
    rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(inten) |-> $past(uo_valid && (uo_kind == 2'd2 ||
                                (uo_kind == 2'd3 && prot_present))));

    // R7
    no_strap_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(inten) && !$past(prot_present)) |-> $past(uo_valid && uo_kind == 2'd2));

    // R8
    accept_gate_chk: assert property (@(posedge clk) disable iff (rst)
        int_accept |-> (inten && irq_pending && test_point));
endmodule

bind iedc_ctrl iedc_ctrl_chk u_iedc_chk (
    .clk          (clk),
    .rst          (rst),
    .uo_valid     (uo_valid),
    .uo_kind      (uo_kind),
    .prot_present (prot_present),
    .irq_pending  (irq_pending),
    .test_point   (test_point),
    .inten        (inten),
    .int_accept   (int_accept)
);

// File: tb/iedc_ctrl_bench.sv
module iedc_ctrl_bench;
    localparam int LIM = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       uo_valid = 1'b0;
    logic [1:0] uo_kind = 2'd0;
    logic       prot_present = 1'b0;
    logic       irq_pending = 1'b0;
    logic       test_point = 1'b0;
    logic       inten;
    logic       int_accept;

    int total = 0;
    int bad = 0;
    logic m_inten = 1'b0;
    int   m_cnt = 0;

    iedc_ctrl #(.IND_LIMIT(LIM)) u_iedc_ctrl (
        .clk(clk), .rst(rst), .uo_valid(uo_valid), .uo_kind(uo_kind),
        .prot_present(prot_present), .irq_pending(irq_pending),
        .test_point(test_point), .inten(inten), .int_accept(int_accept)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string req_of(input logic v, input logic [1:0] k, input logic s);
        if (!v)         return "R6 idle hold";
        if (k == 2'd1)  return "R2 interrupt-off";
        if (k == 2'd2)  return "R3 dispatch";
        if (k == 2'd0)  return "R5 run restart";
        if (s)          return "R4 indirect release";
        return "R7 no strap";
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        uo_valid = 1'b0;
        @(posedge clk);
        #1;
        m_inten = 1'b0;
        m_cnt = 0;
        check("R1 reset", inten, 1'b0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input logic v, input logic [1:0] k, input logic p, input logic t);
        @(negedge clk);
        uo_valid = v;
        uo_kind = k;
        irq_pending = p;
        test_point = t;
        #2;
        check("R8 accept", int_accept, m_inten & p & t);
        @(posedge clk);
        #1;
        if (v) begin
            case (k)
                2'd1: begin m_inten = 1'b0; m_cnt = 0; end
                2'd2: begin m_inten = 1'b1; m_cnt = 0; end
                2'd0: m_cnt = 0;
                default: begin
                    if (m_cnt < LIM) m_cnt++;
                    if (prot_present && m_cnt == LIM) m_inten = 1'b1;
                end
            endcase
        end
        check(req_of(v, k, prot_present), inten, m_inten);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        for (int s = 0; s < 2; s++) begin
            prot_present = s[0];
            do_reset();
            for (int code = 0; code < 625; code++) begin
                int c;
                if (code % 7 == 3) do_reset();
                c = code;
                for (int i = 0; i < 4; i++) begin
                    int d;
                    int pt;
                    d = c % 5;
                    c = c / 5;
                    pt = code + i;
                    if (d == 4) step(1'b0, 2'(pt), pt[0], pt[1]);
                    else        step(1'b1, 2'(d), pt[0], pt[1]);
                end
            end
        end
        // R4: a long run keeps the flag set and saturates
        prot_present = 1'b1;
        do_reset();
        for (int i = 0; i < 6; i++) step(1'b1, 2'd3, 1'b1, 1'b1);
        step(1'b1, 2'd1, 1'b1, 1'b1);
        // R5: two steps, other, two steps stays low
        step(1'b1, 2'd3, 1'b0, 1'b0);
        step(1'b1, 2'd3, 1'b0, 1'b0);
        step(1'b1, 2'd0, 1'b0, 1'b0);
        step(1'b1, 2'd3, 1'b0, 1'b0);
        step(1'b1, 2'd3, 1'b0, 1'b0);
        step(1'b1, 2'd3, 1'b1, 1'b1);
        step(1'b0, 2'd0, 1'b1, 1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule